// File: doc/BRIEF.md
# Ethernet Status LED and GPIO Controller

This block owns three shared pads. Each pad serves either as a general-purpose I/O line or as an active-low Ethernet status indicator. Pad 0 shows the speed, pad 1 shows link and activity, and pad 2 shows full duplex. The block takes live PHY status levels, single-cycle transmit and receive activity strobes, and a per-pad configuration. For each pad it produces a drive-enable and a data value for a tri-state pad cell, and it returns a synchronized copy of the pad levels.

The link/activity indicator stays lit while a link is up. An activity strobe blanks it for a fixed off window. After that it stays lit for a guaranteed minimum window before another blink can start. Strobes that arrive inside either window leave at most one pending blink. The millisecond timebase comes from a clock-enable prescaler whose ratio is set by parameters. A speed-select strap is captured while reset is held and is then frozen.

Top module: `eth_led_gpio`

## Requirements
- R1: With pad 0 in LED mode, the pad is driven low (oe=1, data=0) while any of 100 Mb/s, auto-negotiation or cable-disconnected is true. It is released (oe=0) only when all three are false, which is 10 Mb/s operation.
- R2: With link up and no activity, pad 1 in LED mode is driven low continuously.
- R3: An activity strobe (tx or rx) seen with the link up and the indicator idle releases pad 1 from the next cycle for exactly BLINK_MS*CLK_HZ/TICK_HZ cycles.
- R4: After the off window, pad 1 is driven low for at least the same length of time. Strobes seen during the off or minimum-on window leave one pending blink. That blink starts right at the end of the minimum-on window, and any further strobes in those windows add nothing more.
- R5: With the link down, pad 1 is released regardless of activity. Any blink in progress and any pending blink are discarded, so restoring the link lights the indicator steadily.
- R6: With pad 2 in LED mode, the pad is driven low only while the link is up and full duplex is reported.
- R7: A pad in LED mode (cfg_led bit = 1, which overrides the other bits) acts as open drain: data is always 0 and oe=1 exactly when the indicator is lit.
- R8: A pad in GPIO output mode (cfg_dir bit = 1) with cfg_od bit = 0 is push-pull, giving oe=1 and data equal to the output bit. With cfg_od bit = 1 it is open drain, giving data=0 and oe equal to the inverse of the output bit.
- R9: A pad in input mode (cfg_led = 0, cfg_dir = 0) has oe=0. Its pad level appears on gpi_data_o through two flip-flops, so gpi_data_o shows the level two clock edges after it is applied.
- R10: speed_sel_o takes the strap value present at the last clock edge while reset is asserted and holds it while reset stays deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_strap_i | input | 1 | Speed-select strap, captured during reset |
| phy_link_i | input | 1 | PHY reports a valid link |
| phy_fast_i | input | 1 | PHY operates at 100 Mb/s |
| phy_aneg_i | input | 1 | Auto-negotiation in progress |
| phy_nocable_i | input | 1 | Cable disconnected |
| phy_fdx_i | input | 1 | Full-duplex operation |
| tx_act_i | input | 1 | Transmit activity strobe |
| rx_act_i | input | 1 | Receive activity strobe |
| cfg_led_i | input | 3 | Per-pad LED mode enable |
| cfg_dir_i | input | 3 | Per-pad direction, 1 = output |
| cfg_od_i | input | 3 | Per-pad output type, 1 = open drain |
| gpo_data_i | input | 3 | Per-pad GPIO output value |
| pad_in_i | input | 3 | Pad levels from the input buffers |
| pad_oe_o | output | 3 | Per-pad drive enable |
| pad_do_o | output | 3 | Per-pad drive data |
| gpi_data_o | output | 3 | Synchronized pad levels |
| speed_sel_o | output | 1 | Captured speed-select strap |

## Verification
The embedded properties assume that the PHY status levels and the activity strobes are synchronous to clk and stable around each rising edge. They also assume the strap is steady across the last reset edge. The pad inputs may change at any time, since they pass through the synchronizer. The bench changes every input at the falling edge and samples outputs there too. It times every expected change of pad 1 by counting falling edges from the one that raised the strobe. It lowers the link only between edges, so the link-down properties see clean levels.

// File: rtl/eth_led_gpio.sv
module eth_led_gpio #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int TICK_HZ  = 1000,
  parameter int BLINK_MS = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_strap_i,
  input  logic       phy_link_i,
  input  logic       phy_fast_i,
  input  logic       phy_aneg_i,
  input  logic       phy_nocable_i,
  input  logic       phy_fdx_i,
  input  logic       tx_act_i,
  input  logic       rx_act_i,
  input  logic [2:0] cfg_led_i,
  input  logic [2:0] cfg_dir_i,
  input  logic [2:0] cfg_od_i,
  input  logic [2:0] gpo_data_i,
  input  logic [2:0] pad_in_i,
  output logic [2:0] pad_oe_o,
  output logic [2:0] pad_do_o,
  output logic [2:0] gpi_data_o,
  output logic       speed_sel_o
);

  localparam int NPIN = 3;
  localparam int DIV  = CLK_HZ / TICK_HZ;
  localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int MW   = (BLINK_MS > 1) ? $clog2(BLINK_MS) + 1 : 1;

  typedef enum logic [1:0] {S_IDLE, S_OFF, S_MINON} blink_t;

  blink_t          st;
  logic            pend;
  logic [PW-1:0]   presc;
  logic [MW-1:0]   msc;
  logic [NPIN-1:0] sync1, sync2;
  logic [NPIN-1:0] led_n;
  logic            spd_q;

  wire act        = tx_act_i | rx_act_i;
  wire tick       = presc == PW'(DIV - 1);
  wire phase_done = tick && (msc == MW'(BLINK_MS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) spd_q <= speed_strap_i;
  end
  assign speed_sel_o = spd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pend  <= 1'b0;
      presc <= '0;
      msc   <= '0;
    end else if (!phy_link_i) begin
      st    <= S_IDLE;
      pend  <= 1'b0;
      presc <= '0;
      msc   <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          presc <= '0;
          msc   <= '0;
          if (act) st <= S_OFF;
        end
        default: begin
          if (tick) begin
            presc <= '0;
            msc   <= msc + 1'b1;
          end else begin
            presc <= presc + 1'b1;
          end
          if (phase_done) begin
            msc <= '0;
            if (st == S_OFF) begin
              st   <= S_MINON;
              pend <= pend | act;
            end else if (pend | act) begin
              st   <= S_OFF;
              pend <= 1'b0;
            end else begin
              st   <= S_IDLE;
            end
          end else if (act) begin
            pend <= 1'b1;
          end
        end
      endcase
    end
  end

  assign led_n[0] = ~(phy_fast_i | phy_aneg_i | phy_nocable_i);
  assign led_n[1] = ~phy_link_i | (st == S_OFF);
  assign led_n[2] = ~(phy_link_i & phy_fdx_i);

  for (genvar i = 0; i < NPIN; i++) begin : g_pad
    assign pad_oe_o[i] = cfg_led_i[i] ? ~led_n[i]
                                      : cfg_dir_i[i] & (~cfg_od_i[i] | ~gpo_data_i[i]);
    assign pad_do_o[i] = ~cfg_led_i[i] & cfg_dir_i[i] & ~cfg_od_i[i] & gpo_data_i[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_in_i;
      sync2 <= sync1;
    end
  end
  assign gpi_data_o = sync2;

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  p_strap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(speed_sel_o));

  p_nolink_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_link_i |=> (st == S_IDLE && !pend));

  p_off_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF && $past(st) != S_OFF) |-> $past(act || pend));

  p_off_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_link_i && st == S_OFF && !phase_done) |=> st == S_OFF);

  p_minon_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_link_i && st == S_MINON && !phase_done) |=> st == S_MINON);

  p_sync_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> gpi_data_o == $past(pad_in_i, 2));

  p_led_opendrain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_led_i[0] |-> (!pad_do_o[0] &&
                      pad_oe_o[0] == (phy_fast_i | phy_aneg_i | phy_nocable_i)));

endmodule

// File: tb/eth_led_gpio_tb_top.sv
module eth_led_gpio_tb_top;
  localparam int CLK_HZ = 10_000, TICK_HZ = 1000, BLINK_MS = 80;
  localparam int N = BLINK_MS * (CLK_HZ / TICK_HZ);

  logic clk = 1'b0, rst_n = 1'b0;
  logic strap, link, fast, aneg, nocable, fdx, tx, rx;
  logic [2:0] cled, cdir, cod, gpo, pin;
  logic [2:0] oe, dout, gpi;
  logic spd;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  eth_led_gpio #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .BLINK_MS(BLINK_MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .speed_strap_i(strap), .phy_link_i(link),
    .phy_fast_i(fast), .phy_aneg_i(aneg), .phy_nocable_i(nocable), .phy_fdx_i(fdx),
    .tx_act_i(tx), .rx_act_i(rx), .cfg_led_i(cled), .cfg_dir_i(cdir), .cfg_od_i(cod),
    .gpo_data_i(gpo), .pad_in_i(pin), .pad_oe_o(oe), .pad_do_o(dout),
    .gpi_data_o(gpi), .speed_sel_o(spd));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit use_rx);
    if (use_rx) rx = 1'b1; else tx = 1'b1;
    step(1);
    tx = 1'b0; rx = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 strap captured", int'(spd), 1);
    chk("R9 input mode oe after reset", int'(oe), 0);
    strap = 1'b0;
    step(5);
    chk("R10 strap held", int'(spd), 1);
  endtask

  task automatic t_speed;
    cled = 3'b111; link = 1'b1;
    fast = 1'b1; #1;
    chk("R1 100M lit", int'(oe[0]), 1);
    chk("R7 LED data low", int'(dout[0]), 0);
    step(1); fast = 1'b0; aneg = 1'b1; #1;
    chk("R1 autoneg lit", int'(oe[0]), 1);
    step(1); aneg = 1'b0; nocable = 1'b1; #1;
    chk("R1 no cable lit", int'(oe[0]), 1);
    step(1); nocable = 1'b0; #1;
    chk("R1 10M released", int'(oe[0]), 0);
    chk("R7 LED data low released", int'(dout[0]), 0);
    step(1);
  endtask

  task automatic t_fdx;
    cled = 3'b111; link = 1'b1; fdx = 1'b1; #1;
    chk("R6 full duplex lit", int'(oe[2]), 1);
    step(1); fdx = 1'b0; #1;
    chk("R6 half duplex released", int'(oe[2]), 0);
    step(1); fdx = 1'b1; link = 1'b0; #1;
    chk("R6 no link released", int'(oe[2]), 0);
    step(1); link = 1'b1; fdx = 1'b0;
    step(2);
  endtask

  task automatic t_steady;
    cled = 3'b111; link = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step(500);
      chk("R2 steady link lit", int'(oe[1]), 1);
    end
  endtask

  task automatic t_blink;
    cled = 3'b111; link = 1'b1;
    pulse(1'b0);
    chk("R3 off after strobe", int'(oe[1]), 0);
    step(98); pulse(1'b1);
    step(99); pulse(1'b0);
    step(N - 200);
    chk("R3 off through last cycle", int'(oe[1]), 0);
    step(1);
    chk("R4 on after off window", int'(oe[1]), 1);
    step(48); pulse(1'b1);
    step(N - 50);
    chk("R4 minimum on held", int'(oe[1]), 1);
    step(1);
    chk("R4 pending blink starts", int'(oe[1]), 0);
    step(N - 1);
    chk("R3 second off window length", int'(oe[1]), 0);
    step(1);
    chk("R4 on after second blink", int'(oe[1]), 1);
    step(N + 49);
    chk("R4 only one pending blink", int'(oe[1]), 1);
  endtask

  task automatic t_nolink;
    cled = 3'b111; link = 1'b1;
    pulse(1'b0);
    step(10); pulse(1'b1);
    chk("R3 off during blink", int'(oe[1]), 0);
    link = 1'b0; step(1);
    chk("R5 released without link", int'(oe[1]), 0);
    pulse(1'b0);
    chk("R5 activity ignored without link", int'(oe[1]), 0);
    link = 1'b1; step(1);
    chk("R5 lit on link restore", int'(oe[1]), 1);
    step(2 * N + 5);
    chk("R5 no leftover blink", int'(oe[1]), 1);
  endtask

  task automatic t_gpio;
    cled = 3'b000; cdir = 3'b111; cod = 3'b000; gpo = 3'b101; #1;
    chk("R8 push-pull oe", int'(oe), 7);
    chk("R8 push-pull data", int'(dout), 5);
    step(1); cod = 3'b111; #1;
    chk("R8 open-drain oe", int'(oe), 2);
    chk("R8 open-drain data", int'(dout), 0);
    step(1); cdir = 3'b000; pin = 3'b000;
    step(3);
    chk("R9 input mode oe", int'(oe), 0);
    pin = 3'b110; step(1);
    chk("R9 one edge still old", int'(gpi), 0);
    step(1);
    chk("R9 two edges new value", int'(gpi), 6);
  endtask

  initial begin
    strap = 1'b1; link = 1'b0; fast = 1'b0; aneg = 1'b0; nocable = 1'b0; fdx = 1'b0;
    tx = 1'b0; rx = 1'b0; cled = '0; cdir = '0; cod = '0; gpo = '0; pin = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_speed;
    t_fdx;
    t_steady;
    t_blink;
    t_nolink;
    t_gpio;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule